// File: doc/BRIEF.md
# Addressed Serial Display-Data Receiver

This block sits in front of a two-digit multiplexed display timing engine. A controller sends it a three-wire synchronous stream: a serial clock, a data line and an enable line. While the enable is low, the controller clocks in an address byte. While the enable is high, it clocks in one fixed-length frame. That frame carries the on/off state of 74 segments (one half for each digit), a 10-bit dimmer value, a dimmer-mode bit and a test bit. The new frame takes effect when the enable falls, and only if the address named this receiver.

All three serial lines are brought into the system clock domain through a synchroniser chain. Their edges are found there, so the whole block runs on one clock. The holding register changes only when a frame closes. A frame is accepted only if it came after a matching address and held exactly the right number of bits. A frame of the wrong length after a matching address is dropped, and a one-cycle error pulse marks the drop. Traffic for other addresses is dropped without an error.

Top module: `seg_link_rx`

## Requirements
- R1: The address is sampled on each rising serial clock while the enable is low, least significant bit first. The receiver is selected when the first four address bits received are 0,1,0,1 (low nibble 1010b). The upper four bits are don't-care.
- R2: Payload bits are sampled on each rising serial clock while the enable is high. The k-th bit received (k = 0 first) takes frame position k of a 92-bit frame.
- R3: Frame positions 0 to 73 drive seg_o[73:0]. Positions 0 to 36 are the segments of digit 1 and positions 37 to 73 are the segments of digit 2. Positions 74 to 83 drive dim_o[9:0], least significant bit first. Position 84 drives dim_analog_o (1 = analog dimmer, 0 = digital). Position 85 drives test_o. Positions 86 to 91 have no effect on any output.
- R4: When the enable falls after a matching address and exactly 92 payload bits, all outputs take the new frame. This happens on the third system clock edge after the enable pin falls. At no other time do the held outputs change.
- R5: When the enable falls after a matching address but a payload count other than 92, the held outputs stay unchanged. frame_err_o is then high for exactly one system clock cycle.
- R6: When the address does not match, closing the frame changes no output and raises no error.
- R7: The address is forgotten at every enable fall. A frame sent without a fresh address phase is treated as not matching.
- R8: A rising serial clock that lands in the same system clock cycle as the enable fall is not counted as a payload bit.
- R9: After reset, seg_o, dim_o, dim_analog_o, test_o and frame_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock from the controller |
| ser_dat_i | input | 1 | Serial data from the controller |
| ser_en_i | input | 1 | Serial enable: low for the address phase, high for the payload phase |
| seg_o | output | 74 | Held segment states; [36:0] for digit 1, [73:37] for digit 2 |
| dim_o | output | 10 | Held dimmer value |
| dim_analog_o | output | 1 | Held dimmer mode, 1 = analog |
| test_o | output | 1 | Held test bit |
| frame_err_o | output | 1 | One-cycle pulse when a matched frame had the wrong length |

## Verification
Closing a frame and shifting a serial bit can fall in the same system clock cycle. The bench provokes this by sending 91 payload bits and then raising the serial clock at the same instant the enable drops. Both lines pass through identical synchronisers, so the two edges are detected together. The bench then expects a length error and an unchanged holding register. If that last edge had been counted as the 92nd bit, the design would have committed the frame instead.

// File: rtl/seg_link_pkg.sv
package seg_link_pkg;
   localparam int SEG_BITS   = 74;
   localparam int DIM_BITS   = 10;
   localparam int SPARE_BITS = 6;
   localparam int ADDR_BITS  = 8;
   localparam int MATCH_BITS = 4;

   // outcome of a frame close (enable falling edge)
   typedef enum logic [1:0] {
      EV_NONE,
      EV_COMMIT,
      EV_LEN_ERR,
      EV_FOREIGN
   } close_ev_t;

   function automatic int frame_bits(input int seg, input int dim, input int spare);
      return seg + dim + 2 + spare;
   endfunction
endpackage

// File: rtl/seg_link_sync.sv
module seg_link_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] prev
);
   // STAGES flops of synchroniser plus one history flop for edge detection
   for (genvar i = 0; i <= STAGES; i++) begin : g_st
      logic [WIDTH-1:0] q;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_st[i-1].q;
         end
      end
   end

   assign lvl  = g_st[STAGES-1].q;
   assign prev = g_st[STAGES].q;
endmodule

// File: rtl/seg_link_addr.sv
module seg_link_addr #(
   parameter int                ADDR_W    = 8,
   parameter int                CMP_W     = 4,
   parameter logic [CMP_W-1:0]  MATCH     = 4'b1010,
   parameter bit                LSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic bit_in,
   input  logic clear,
   input  logic capture,
   output logic hit
);
   logic [ADDR_W-1:0] sh;
   logic [ADDR_W-1:0] sh_nxt;

   if (LSB_FIRST) begin : g_lsb
      assign sh_nxt = {bit_in, sh[ADDR_W-1:1]};
   end else begin : g_msb
      assign sh_nxt = {sh[ADDR_W-2:0], bit_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         hit <= 1'b0;
      end else begin
         if (clear)         sh <= '0;
         else if (shift_en) sh <= sh_nxt;

         if (clear)        hit <= 1'b0;
         else if (capture) hit <= (sh[CMP_W-1:0] == MATCH);
      end
   end
endmodule

// File: rtl/seg_link_frame.sv
module seg_link_frame #(
   parameter int LEN = 92
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           shift_en,
   input  logic           bit_in,
   output logic [LEN-1:0] payload,
   output logic           len_ok
);
   localparam int CNT_W = $clog2(LEN + 2);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         payload <= '0;
      end else begin
         if (start)                        cnt <= CNT_W'(shift_en);
         else if (shift_en && cnt != '1)   cnt <= cnt + 1'b1;

         if (shift_en) payload <= {bit_in, payload[LEN-1:1]};
      end
   end

   assign len_ok = (cnt == CNT_W'(LEN));
endmodule

// File: rtl/seg_link_rx.sv
module seg_link_rx
   import seg_link_pkg::*;
#(
   parameter int               SEG_W          = SEG_BITS,
   parameter int               DIM_W          = DIM_BITS,
   parameter int               SPARE_W        = SPARE_BITS,
   parameter int               ADDR_W         = ADDR_BITS,
   parameter int               CMP_W          = MATCH_BITS,
   parameter logic [CMP_W-1:0] DEV_ID         = 4'b1010,
   parameter int               SYNC_STAGES    = 2,
   parameter bit               ADDR_LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk_i,
   input  logic             ser_dat_i,
   input  logic             ser_en_i,
   output logic [SEG_W-1:0] seg_o,
   output logic [DIM_W-1:0] dim_o,
   output logic             dim_analog_o,
   output logic             test_o,
   output logic             frame_err_o
);
   localparam int FRAME_W   = frame_bits(SEG_W, DIM_W, SPARE_W);
   localparam int OFF_DIM   = SEG_W;
   localparam int OFF_MODE  = OFF_DIM + DIM_W;
   localparam int OFF_TEST  = OFF_MODE + 1;
   localparam int OFF_SPARE = OFF_TEST + 1;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("seg_link_rx: SYNC_STAGES must be at least 2");
   end
   if (CMP_W > ADDR_W) begin : g_chk_cmp
      $error("seg_link_rx: CMP_W exceeds ADDR_W");
   end
   if (SEG_W % 2 != 0) begin : g_chk_seg
      $error("seg_link_rx: SEG_W must split evenly over two digits");
   end
   if (SPARE_W < 1) begin : g_chk_spare
      $error("seg_link_rx: SPARE_W must be at least 1");
   end

   // index 0 = serial clock, 1 = data, 2 = enable
   logic [2:0] s_lvl, s_prev;

   seg_link_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_en_i, ser_dat_i, ser_clk_i}),
      .lvl  (s_lvl),
      .prev (s_prev)
   );

   logic sclk_rise, en_rise, en_fall, en_lvl;
   assign en_lvl    = s_lvl[2];
   assign sclk_rise = s_lvl[0] & ~s_prev[0];
   assign en_rise   = s_lvl[2] & ~s_prev[2];
   assign en_fall   = ~s_lvl[2] & s_prev[2];

   logic unused_dat_prev;
   assign unused_dat_prev = s_prev[1];

   logic addr_hit;

   seg_link_addr #(
      .ADDR_W   (ADDR_W),
      .CMP_W    (CMP_W),
      .MATCH    (DEV_ID),
      .LSB_FIRST(ADDR_LSB_FIRST)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(sclk_rise & ~en_lvl),
      .bit_in  (s_lvl[1]),
      .clear   (en_fall),
      .capture (en_rise),
      .hit     (addr_hit)
   );

   logic [FRAME_W-1:0] payload;
   logic               len_ok;

   seg_link_frame #(.LEN(FRAME_W)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (en_rise),
      .shift_en(sclk_rise & en_lvl),
      .bit_in  (s_lvl[1]),
      .payload (payload),
      .len_ok  (len_ok)
   );

   logic unused_spare;
   assign unused_spare = ^payload[FRAME_W-1:OFF_SPARE];

   close_ev_t close_ev;

   always_comb begin
      if (!en_fall)     close_ev = EV_NONE;
      else if (!addr_hit) close_ev = EV_FOREIGN;
      else if (len_ok)  close_ev = EV_COMMIT;
      else              close_ev = EV_LEN_ERR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_o        <= '0;
         dim_o        <= '0;
         dim_analog_o <= 1'b0;
         test_o       <= 1'b0;
         frame_err_o  <= 1'b0;
      end else begin
         frame_err_o <= (close_ev == EV_LEN_ERR);
         if (close_ev == EV_COMMIT) begin
            seg_o        <= payload[SEG_W-1:0];
            dim_o        <= payload[OFF_DIM +: DIM_W];
            dim_analog_o <= payload[OFF_MODE];
            test_o       <= payload[OFF_TEST];
         end
      end
   end
endmodule

// File: rtl/seg_link_rx_chk.sv
module seg_link_rx_chk #(
   parameter int SEG_W = 74,
   parameter int DIM_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_fall,
   input logic             addr_hit,
   input logic             frame_err_o,
   input logic [SEG_W-1:0] seg_o,
   input logic [DIM_W-1:0] dim_o,
   input logic             dim_analog_o,
   input logic             test_o
);
   AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> !frame_err_o); // R5

   AST_ERR_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> $stable({seg_o, dim_o, dim_analog_o, test_o})); // R5

   AST_ERR_ONLY_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> $past(en_fall)); // R5

   AST_ERR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> $past(addr_hit)); // R6

   AST_HOLD_ONLY_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_fall) |-> $stable({seg_o, dim_o, dim_analog_o, test_o})); // R4
endmodule

bind seg_link_rx seg_link_rx_chk #(.SEG_W(SEG_W), .DIM_W(DIM_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en_fall     (en_fall),
   .addr_hit    (addr_hit),
   .frame_err_o (frame_err_o),
   .seg_o       (seg_o),
   .dim_o       (dim_o),
   .dim_analog_o(dim_analog_o),
   .test_o      (test_o)
);

// File: tb/sim_seg_link_rx.sv
`timescale 1ns/1ps
module sim_seg_link_rx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
   logic [73:0] seg;
   logic [9:0]  dim;
   logic        dim_analog, test_bit, frame_err;

   always #5 clk = ~clk;

   seg_link_rx u0 (
      .clk(clk), .rst_n(rst_n),
      .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_en_i(ser_en),
      .seg_o(seg), .dim_o(dim), .dim_analog_o(dim_analog),
      .test_o(test_bit), .frame_err_o(frame_err)
   );

   typedef struct {
      logic [85:0] hold;
      bit          err;
      string       req;
   } exp_t;

   exp_t        sb_q[$];
   logic [85:0] model_hold = '0;
   int          n_checks = 0;
   int          n_fail = 0;
   int          err_pulses = 0;
   bit          rst_done = 1'b0;
   bit          all_done = 1'b0;

   always @(negedge clk) if (frame_err) err_pulses++;

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ser_bit(input logic b);
      ser_dat = b;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
   endtask

   function automatic logic [91:0] mk_frame(input logic [73:0] s, input logic [9:0] d,
                                            input logic m, input logic t, input logic [5:0] sp);
      return {sp, t, m, d, s};
   endfunction

   // driver: sends one transaction and pushes the expected result
   task automatic send(input string req, input bit with_addr, input logic [7:0] addr,
                       input logic [91:0] frame, input int nbits, input bit coincide);
      exp_t e;
      bit   hit, ok;
      if (with_addr)
         for (int i = 0; i < 8; i++) ser_bit(addr[i]);
      wait_clk(4);
      ser_en = 1'b1;
      wait_clk(4);
      for (int k = 0; k < nbits; k++) ser_bit(k < 92 ? frame[k] : 1'b0);
      hit = with_addr && (addr[3:0] == 4'b1010);
      ok  = hit && (nbits == 92) && !coincide;
      if (ok) model_hold = frame[85:0];
      e.hold = model_hold;
      e.err  = hit && !ok;
      e.req  = req;
      sb_q.push_back(e);
      if (coincide) begin
         ser_dat = frame[nbits];
         wait_clk(4);
         ser_clk = 1'b1;
         ser_en  = 1'b0;
         wait_clk(4);
         ser_clk = 1'b0;
      end else begin
         wait_clk(4);
         ser_en = 1'b0;
      end
      wait_clk(12);
   endtask

   // monitor: pops one expectation per frame close
   initial begin
      exp_t e;
      int   p0;
      wait (rst_done);
      forever begin
         @(negedge ser_en);
         p0 = err_pulses;
         wait_clk(8);
         e = sb_q.pop_front();
         check(e.req, "seg_o (R3)",        128'(seg),        128'(e.hold[73:0]));
         check(e.req, "dim_o (R3)",        128'(dim),        128'(e.hold[83:74]));
         check(e.req, "dim_analog_o (R3)", 128'(dim_analog), 128'(e.hold[84]));
         check(e.req, "test_o (R3)",       128'(test_bit),   128'(e.hold[85]));
         check(e.req, "error pulses (R5)", 128'(err_pulses - p0), 128'(e.err));
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      // R9: reset state
      check("R9", "seg_o", 128'(seg), 128'(0));
      check("R9", "dim_o", 128'(dim), 128'(0));
      check("R9", "mode/test", 128'({dim_analog, test_bit}), 128'(0));
      check("R9", "frame_err_o", 128'(frame_err), 128'(0));
      rst_done = 1'b1;
      wait_clk(2);

      // R1 R2 R4: matching address, full frame, spare bits zero
      send("R4", 1'b1, 8'h3A,
           mk_frame({37'h05A5A5A5A5, 37'h1234567890}, 10'h2C7, 1'b0, 1'b0, 6'h00), 92, 1'b0);
      // R1 R3: upper address bits differ, mode/test set, spare bits all ones
      send("R3", 1'b1, 8'hFA,
           mk_frame({37'h1F00FF00F1, 37'h0ACE1F00D5}, 10'h135, 1'b1, 1'b1, 6'h3F), 92, 1'b0);
      // R6: low nibble wrong
      send("R6", 1'b1, 8'h0B,
           mk_frame({74{1'b1}}, 10'h3FF, 1'b0, 1'b0, 6'h15), 92, 1'b0);
      // R5: one bit short
      send("R5", 1'b1, 8'h1A,
           mk_frame({74{1'b0}}, 10'h001, 1'b0, 1'b0, 6'h00), 91, 1'b0);
      // R5: one bit long
      send("R5", 1'b1, 8'h2A,
           mk_frame({74{1'b0}}, 10'h002, 1'b1, 1'b0, 6'h00), 93, 1'b0);
      // R7: no address phase after a previous frame close
      send("R7", 1'b0, 8'h0A,
           mk_frame({37'h0F0F0F0F0F, 37'h1111111111}, 10'h0AA, 1'b1, 1'b1, 6'h00), 92, 1'b0);
      // R8: 92nd clock edge lands with the enable fall
      send("R8", 1'b1, 8'h4A,
           mk_frame({37'h0123456789, 37'h0FEDCBA987}, 10'h0F0, 1'b0, 1'b1, 6'h00), 91, 1'b1);
      // R4 R2: new good frame after errors, dimmer at full scale
      send("R4", 1'b1, 8'h5A,
           mk_frame({37'h1000000001, 37'h0000000003}, 10'h3FF, 1'b1, 1'b0, 6'h2A), 92, 1'b0);

      wait_clk(20);
      all_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule